// File: doc/BRIEF.md
# Delay Window Centering Calibrator

This block tunes a programmable delay tap on a memory or high-speed serial interface. When started, it drives the tap to a nominal code and asks an external pattern checker to run one trial at that setting. In each trial the checker writes a stress pattern and reads it back; any mismatch counts as a fail. The block then walks the tap downward one code per trial until a trial fails, and records the lowest passing code. It returns to the code just above nominal and walks upward in the same way to find the highest passing code. At the end it programs the midpoint of the two edges.

Every tap change is followed by a settle delay, set by the `settle_cycles` input, before the next trial is requested. Only one trial is outstanding at any time, and the tap is frozen while it runs. When the tap reaches either end of its range without a failure, that end code becomes the edge. If the nominal code itself fails, the block leaves the tap at nominal, raises an error flag and finishes.

Top module: `dwc_calibrator`

## Requirements
- R1: After reset, `tap` equals NOMINAL (32 by default), `edge_lo` and `edge_hi` equal NOMINAL, and `done`, `cal_err` and `trial_req` are 0.
- R2: A `start` pulse accepted while idle loads `tap` with NOMINAL and clears `cal_err`. The first trial runs at NOMINAL.
- R3: `trial_req` first rises exactly `settle_cycles`+1 clock edges after the edge that changed the tap or accepted `start`. The tap does not change while a trial is outstanding.
- R4: After the nominal code passes, the tap decreases by one code per trial. `edge_lo` is the last passing code before the first fail.
- R5: The upward search starts at NOMINAL+1 and increases by one code per trial. `edge_hi` is the last passing code before the first fail.
- R6: If the tap reaches code 0 (downward) or code 2^TAP_W-1 (upward) and that trial passes, the end code is taken as the edge.
- R7: On successful completion, `tap` = (`edge_lo` + `edge_hi`) >> 1, rounded down.
- R8: If the trial at NOMINAL fails, `cal_err` goes to 1 and `done` pulses. `tap`, `edge_lo` and `edge_hi` all stay at NOMINAL.
- R9: `done` is high for exactly one cycle. After it, `tap`, `edge_lo`, `edge_hi` and `cal_err` hold their values until the next `start`.
- R10: `trial_req` is a one-cycle pulse. No new request is made until `trial_ack` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (accepted only when idle) |
| settle_cycles | input | SETTLE_W | Extra wait cycles after each tap change |
| trial_req | output | 1 | One-cycle request for a pattern trial at the current tap |
| trial_ack | input | 1 | Trial result valid |
| trial_pass | input | 1 | Trial result: 1 = pattern read back correctly |
| tap | output | TAP_W | Delay tap code |
| done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | Nominal code failed |
| edge_lo | output | TAP_W | Lowest passing code found |
| edge_hi | output | TAP_W | Highest passing code found |

## Verification
The bench models the delay line as a pass window and sweeps it through several cases. In a centred window, a wrong sweep direction or step size shows up as a wrong trial count. A window touching code 0 or the top code catches a design that wraps or records a failing code past the limit. A window holding only the nominal code, and odd sums, catch a midpoint that rounds up or an edge that is off by one. A window that excludes nominal catches a design that keeps sweeping or moves the tap instead of flagging the error. A monitor checks the gap between each tap change and the next request against several settle values and response latencies. A miscounted settle timer or a request that arrives too early fails that check.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } dwc_state_e;

  typedef enum logic [1:0] {
    PH_NOM,
    PH_LO,
    PH_HI
  } dwc_phase_e;

endpackage

// File: rtl/dwc_settle_timer.sv
module dwc_settle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dwc_midpoint.sv
module dwc_midpoint #(
  parameter int TAP_W = 6
) (
  input  logic [TAP_W-1:0] lo,
  input  logic [TAP_W-1:0] hi,
  output logic [TAP_W-1:0] mid
);

  logic [TAP_W:0] sum;

  assign sum = {1'b0, lo} + {1'b0, hi};
  assign mid = sum[TAP_W:1];

endmodule

// File: rtl/dwc_calibrator.sv
module dwc_calibrator
  import dwc_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int NOMINAL  = 32,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                trial_req,
  input  logic                trial_ack,
  input  logic                trial_pass,
  output logic [TAP_W-1:0]    tap,
  output logic                done,
  output logic                cal_err,
  output logic [TAP_W-1:0]    edge_lo,
  output logic [TAP_W-1:0]    edge_hi
);

  localparam int               TAP_MAX_I  = (1 << TAP_W) - 1;
  localparam logic [TAP_W-1:0] TAP_MAX    = TAP_MAX_I[TAP_W-1:0];
  localparam logic [TAP_W-1:0] NOM_TAP    = NOMINAL[TAP_W-1:0];
  localparam bit               NOM_AT_TOP = (NOMINAL >= TAP_MAX_I);

  dwc_state_e       state_q, state_d;
  dwc_phase_e       phase_q, phase_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [TAP_W-1:0] lo_q, lo_d;
  logic [TAP_W-1:0] hi_q, hi_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             tmr_load;
  logic             tmr_expired;
  logic [TAP_W-1:0] mid;

  dwc_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (settle_cycles),
    .expired  (tmr_expired)
  );

  dwc_midpoint #(.TAP_W(TAP_W)) u_mid (
    .lo  (lo_q),
    .hi  (hi_q),
    .mid (mid)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    tap_d    = tap_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    done_d   = 1'b0;
    err_d    = err_q;
    tmr_load = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          tap_d    = NOM_TAP;
          lo_d     = NOM_TAP;
          hi_d     = NOM_TAP;
          err_d    = 1'b0;
          phase_d  = PH_NOM;
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_expired) state_d = ST_REQ;
      end
      ST_REQ: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (trial_ack) begin
          if (phase_q == PH_NOM && !trial_pass) begin
            err_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (phase_q != PH_HI) begin
            // downward sweep (nominal pass enters it too)
            if (trial_pass && tap_q != '0) begin
              tap_d    = tap_q - 1'b1;
              phase_d  = PH_LO;
              state_d  = ST_SETTLE;
              tmr_load = 1'b1;
            end else begin
              lo_d = trial_pass ? tap_q : tap_q + 1'b1;
              if (NOM_AT_TOP) begin
                hi_d    = TAP_MAX;
                state_d = ST_FIN;
              end else begin
                tap_d    = NOM_TAP + 1'b1;
                phase_d  = PH_HI;
                state_d  = ST_SETTLE;
                tmr_load = 1'b1;
              end
            end
          end else begin
            // upward sweep
            if (trial_pass && tap_q != TAP_MAX) begin
              tap_d    = tap_q + 1'b1;
              state_d  = ST_SETTLE;
              tmr_load = 1'b1;
            end else begin
              hi_d    = trial_pass ? tap_q : tap_q - 1'b1;
              state_d = ST_FIN;
            end
          end
        end
      end
      ST_FIN: begin
        tap_d   = mid;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_NOM;
      tap_q   <= NOM_TAP;
      lo_q    <= NOM_TAP;
      hi_q    <= NOM_TAP;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      tap_q   <= tap_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign trial_req = (state_q == ST_REQ);
  assign tap       = tap_q;
  assign done      = done_q;
  assign cal_err   = err_q;
  assign edge_lo   = lo_q;
  assign edge_hi   = hi_q;

endmodule

// File: rtl/dwc_calibrator_chk.sv
module dwc_calibrator_chk #(
  parameter int TAP_W   = 6,
  parameter int NOMINAL = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trial_req,
  input logic             trial_ack,
  input logic [TAP_W-1:0] tap,
  input logic             done,
  input logic             cal_err,
  input logic [TAP_W-1:0] edge_lo,
  input logic [TAP_W-1:0] edge_hi
);

  logic           open_q;
  logic [TAP_W:0] esum;

  assign esum = {1'b0, edge_lo} + {1'b0, edge_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (trial_req) open_q <= 1'b1;
    else if (trial_ack) open_q <= 1'b0;
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |=> !trial_req); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |-> !open_q); // R10
  AST_TAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !trial_ack) |=> $stable(tap)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_MIDPOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_err) |-> (tap == esum[TAP_W:1])); // R7
  AST_ERR_AT_NOM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cal_err) |-> (tap == NOMINAL[TAP_W-1:0])); // R8
  AST_EDGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edge_lo <= edge_hi)); // R4

endmodule

bind dwc_calibrator dwc_calibrator_chk #(.TAP_W(TAP_W), .NOMINAL(NOMINAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trial_req (trial_req),
  .trial_ack (trial_ack),
  .tap       (tap),
  .done      (done),
  .cal_err   (cal_err),
  .edge_lo   (edge_lo),
  .edge_hi   (edge_hi)
);

// File: tb/dwc_calibrator_tb.sv
`timescale 1ns/1ps
module dwc_calibrator_tb;

  localparam int TAP_W    = 6;
  localparam int NOMINAL  = 32;
  localparam int SETTLE_W = 4;
  localparam int TMAX     = (1 << TAP_W) - 1;

  logic                clk;
  logic                rst_n;
  logic                start;
  logic [SETTLE_W-1:0] settle_cycles;
  logic                trial_req;
  logic                trial_ack;
  logic                trial_pass;
  logic [TAP_W-1:0]    tap;
  logic                done;
  logic                cal_err;
  logic [TAP_W-1:0]    edge_lo;
  logic [TAP_W-1:0]    edge_hi;

  int n_chk, n_bad;
  int win_lo, win_hi, resp_lat, ack_wait;
  int cyc, last_chg, req_cnt, settle_bad, req_bad;
  logic [TAP_W-1:0] prev_tap;
  logic prev_req;

  dwc_calibrator #(.TAP_W(TAP_W), .NOMINAL(NOMINAL), .SETTLE_W(SETTLE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .trial_req(trial_req), .trial_ack(trial_ack), .trial_pass(trial_pass),
    .tap(tap), .done(done), .cal_err(cal_err), .edge_lo(edge_lo), .edge_hi(edge_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // cycle counter; start acceptance marks a tap load
  always @(posedge clk) begin
    cyc++;
    if (rst_n && start) last_chg = cyc;
  end

  // pattern checker stand-in and request monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      trial_ack = 1'b0;
      trial_pass = 1'b0;
      ack_wait = 0;
      prev_tap = tap;
      prev_req = 1'b0;
    end else begin
      if (tap != prev_tap) last_chg = cyc;
      prev_tap = tap;
      trial_ack = 1'b0;
      if (ack_wait > 0) begin
        ack_wait--;
        if (ack_wait == 0) begin
          trial_ack = 1'b1;
          trial_pass = (int'(tap) >= win_lo) && (int'(tap) <= win_hi);
        end
      end
      if (trial_req) begin
        req_cnt++;
        if (cyc - last_chg != int'(settle_cycles) + 1) settle_bad++;
        if (prev_req) req_bad++;
        ack_wait = resp_lat;
      end
      prev_req = trial_req;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input string name, input int wl, input int wh,
                          input int st, input int lat);
    int exp_lo, exp_hi, exp_tap, exp_trials;
    bit exp_err;
    bit seen;
    int t_lo, t_hi, t_tap, t_err;
    win_lo = wl; win_hi = wh; resp_lat = lat;
    settle_cycles = SETTLE_W'(st);
    req_cnt = 0; settle_bad = 0; req_bad = 0;
    exp_err = (NOMINAL < wl) || (NOMINAL > wh);
    if (exp_err) begin
      exp_lo = NOMINAL; exp_hi = NOMINAL; exp_tap = NOMINAL; exp_trials = 1;
    end else begin
      exp_lo = (wl < 0) ? 0 : wl;
      exp_hi = (wh > TMAX) ? TMAX : wh;
      exp_tap = (exp_lo + exp_hi) >> 1;
      exp_trials = 1 + ((exp_lo > 0) ? NOMINAL - exp_lo + 1 : NOMINAL)
                     + ((exp_hi < TMAX) ? exp_hi + 1 - NOMINAL : TMAX - NOMINAL);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: first trial at nominal
    seen = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      if (trial_req) begin
        seen = 1'b1;
        chk(int'(tap) == NOMINAL, {"R2 first trial tap ", name}, int'(tap), NOMINAL);
      end else @(negedge clk);
    end
    chk(seen, {"R2 first request ", name}, int'(seen), 1);
    seen = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, {"R9 done seen ", name}, int'(seen), 1);
    chk(int'(cal_err) == int'(exp_err), {"R8 cal_err ", name}, int'(cal_err), int'(exp_err));
    chk(int'(edge_lo) == exp_lo, {"R4 R6 edge_lo ", name}, int'(edge_lo), exp_lo);
    chk(int'(edge_hi) == exp_hi, {"R5 R6 edge_hi ", name}, int'(edge_hi), exp_hi);
    chk(int'(tap) == exp_tap, {"R7 R8 final tap ", name}, int'(tap), exp_tap);
    chk(req_cnt == exp_trials, {"R4 R5 trial count ", name}, req_cnt, exp_trials);
    chk(settle_bad == 0, {"R3 settle gap ", name}, settle_bad, 0);
    chk(req_bad == 0, {"R10 request pulse ", name}, req_bad, 0);
    t_lo = int'(edge_lo); t_hi = int'(edge_hi); t_tap = int'(tap); t_err = int'(cal_err);
    @(negedge clk);
    chk(done == 1'b0, {"R9 done width ", name}, int'(done), 0);
    repeat (8) @(negedge clk);
    chk(int'(edge_lo) == t_lo && int'(edge_hi) == t_hi, {"R9 edges held ", name},
        int'(edge_lo) * 100 + int'(edge_hi), t_lo * 100 + t_hi);
    chk(int'(tap) == t_tap && int'(cal_err) == t_err, {"R9 tap held ", name}, int'(tap), t_tap);
    chk(trial_req == 1'b0, {"R10 idle no request ", name}, int'(trial_req), 0);
  endtask

  task automatic test_reset();
    chk(int'(tap) == NOMINAL, "R1 reset tap", int'(tap), NOMINAL);
    chk(int'(edge_lo) == NOMINAL && int'(edge_hi) == NOMINAL, "R1 reset edges",
        int'(edge_lo) * 100 + int'(edge_hi), NOMINAL * 101);
    chk(!done && !cal_err && !trial_req, "R1 reset flags",
        int'(done) + int'(cal_err) + int'(trial_req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; last_chg = 0;
    start = 1'b0; settle_cycles = '0;
    win_lo = 0; win_hi = 0; resp_lat = 1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_case("centred",        20, 44, 0, 1);
    run_case("asymmetric",     30, 50, 3, 2);
    run_case("floor limit",     0, 40, 1, 1);
    run_case("ceiling limit",  10, 63, 7, 3);
    run_case("odd sum",        31, 34, 2, 1);
    run_case("single code",    32, 32, 0, 2);
    run_case("full range",      0, 63, 15, 1);
    run_case("nominal fails",  40, 50, 4, 2);
    run_case("after error",    25, 38, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule